// File: doc/BRIEF.md
# Far-End Performance Report Statistics Accumulator

This block keeps long-running statistics on the link quality that the remote end reports. Once per second, the history logic moves its entries along. On that shift the oldest entry, a single decoded report byte, is offered to this block together with a flag that says whether the entry holds real data. The block classifies the second as errored, severely errored, both or clean. It then advances two 16-bit counters to match. Entries flagged as invalid are skipped.

A separate strobe marks each incoming report whose computed check sequence disagreed with the received one. These strobes are counted in an 8-bit counter. All three counters saturate at their maximum value, and a synchronous clear input zeroes them together. The host reads the counters directly from the output ports. Link decoding and the history shift register itself live in neighbouring blocks.

The report byte layout is fixed by the neighbouring decoder:

| Bits | Field |
|------|-------|
| [2:0] | CRC error-count code |
| 3 | Frame-bit error |
| 4 | Severe framing error |
| 5 | Line violation |
| 6 | Controlled slip |
| 7 | Payload loopback |

Top module: `prm_stat_top`

## Requirements
- R1: While `rstN` is low, all three counters read zero, and they stay zero until a strobe arrives.
- R2: The errored-seconds and severely-errored-seconds counters change only in a cycle where `shiftStb` and `histValid` are both high. A shift with `histValid` low leaves both counters unchanged.
- R3: On a valid shift, `esCount` advances by one when any of these holds: bit 3 (frame-bit error) of `histByte` is set, bit 4 (severe framing error) is set, or the code in bits [2:0] is any value from 2 to 7.
- R4: On a valid shift, `sesCount` advances by one when bit 4 of `histByte` is set or the code in bits [2:0] equals 7.
- R5: A valid shift whose byte has bits 3 and 4 clear and a code of 0 or 1 changes neither seconds counter, whatever the values of bits 5, 6 and 7.
- R6: `errCount` advances by one in every cycle in which `msgErrStb` is high, independently of `shiftStb`, `histValid` and `histByte`.
- R7: Each counter holds at its all-ones value (65535, 65535, 255) when further increments arrive.
- R8: A high `clr` zeroes all three counters at the next clock edge and overrides any strobe in the same cycle.
- R9: A strobe sampled at a rising clock edge is reflected in the counters immediately after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| histByte | input | 8 | Oldest history entry (report byte) |
| histValid | input | 1 | History entry holds valid data |
| shiftStb | input | 1 | One-cycle strobe at each history shift |
| msgErrStb | input | 1 | One-cycle strobe for a report that failed its check |
| esCount | output | 16 | Errored-seconds count |
| sesCount | output | 16 | Severely-errored-seconds count |
| errCount | output | 8 | Count of reports that failed their check |

## Verification
A history shift and a failed-check strobe can land in the same cycle. The bench drives both strobes together with bytes of several classes, including invalid entries. It expects each counter to move exactly as it would if that strobe had come alone. The clear input can also coincide with both strobes. That case is provoked in one cycle, and the bench expects all three counters to read zero afterwards.

// File: rtl/prm_stat_pkg.sv
package prm_stat_pkg;

  // Report byte field positions, fixed by the neighbouring decoder.
  localparam int CODE_LSB   = 0;
  localparam int CODE_W     = 3;
  localparam int FRAME_BIT  = 3;
  localparam int SEVERE_BIT = 4;
  localparam int BYTE_W     = 8;

  // Lowest error-count code that makes a second errored, and the top code.
  localparam logic [CODE_W-1:0] CODE_ERR_MIN = 3'd2;
  localparam logic [CODE_W-1:0] CODE_ERR_TOP = 3'd7;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic clearAll;
    logic bumpEs;
    logic bumpSes;
    logic bumpErr;
  } statStrb_t;

endpackage

// File: rtl/prm_sat_ctr.sv
module prm_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         bump,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic atTop;
  assign atTop = (count == MAXV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (bump && !atTop) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/prm_stat_ctrl.sv
module prm_stat_ctrl
  import prm_stat_pkg::*;
(
  input  logic              clr,
  input  logic [BYTE_W-1:0] histByte,
  input  logic              histValid,
  input  logic              shiftStb,
  input  logic              msgErrStb,
  output statStrb_t         strb
);

  logic [CODE_W-1:0] errCode;
  logic              frameErr;
  logic              severeErr;
  logic              takeSecond;
  logic              isErrored;
  logic              isSevere;
  logic              unusedFields;

  assign errCode      = histByte[CODE_LSB +: CODE_W];
  assign frameErr     = histByte[FRAME_BIT];
  assign severeErr    = histByte[SEVERE_BIT];
  assign unusedFields = ^histByte[BYTE_W-1:SEVERE_BIT+1];

  assign takeSecond = shiftStb && histValid;
  assign isErrored  = frameErr || severeErr || (errCode >= CODE_ERR_MIN);
  assign isSevere   = severeErr || (errCode == CODE_ERR_TOP);

  always_comb begin
    strb.clearAll = clr;
    strb.bumpEs   = takeSecond && isErrored;
    strb.bumpSes  = takeSecond && isSevere;
    strb.bumpErr  = msgErrStb;
  end

endmodule

// File: rtl/prm_stat_dp.sv
module prm_stat_dp
  import prm_stat_pkg::*;
#(
  parameter int ES_W  = 16,
  parameter int SES_W = 16,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  statStrb_t        strb,
  output logic [ES_W-1:0]  esCount,
  output logic [SES_W-1:0] sesCount,
  output logic [ERR_W-1:0] errCount
);

  prm_sat_ctr #(.W(ES_W)) u_esCtr (
    .clk   (clk),
    .rstN  (rstN),
    .clear (strb.clearAll),
    .bump  (strb.bumpEs),
    .count (esCount)
  );

  prm_sat_ctr #(.W(SES_W)) u_sesCtr (
    .clk   (clk),
    .rstN  (rstN),
    .clear (strb.clearAll),
    .bump  (strb.bumpSes),
    .count (sesCount)
  );

  prm_sat_ctr #(.W(ERR_W)) u_errCtr (
    .clk   (clk),
    .rstN  (rstN),
    .clear (strb.clearAll),
    .bump  (strb.bumpErr),
    .count (errCount)
  );

endmodule

// File: rtl/prm_stat_top.sv
module prm_stat_top
  import prm_stat_pkg::*;
#(
  parameter int ES_W  = 16,
  parameter int SES_W = 16,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic [7:0]       histByte,
  input  logic             histValid,
  input  logic             shiftStb,
  input  logic             msgErrStb,
  output logic [ES_W-1:0]  esCount,
  output logic [SES_W-1:0] sesCount,
  output logic [ERR_W-1:0] errCount
);

  statStrb_t strb;

  prm_stat_ctrl u_ctrl (
    .clr       (clr),
    .histByte  (histByte),
    .histValid (histValid),
    .shiftStb  (shiftStb),
    .msgErrStb (msgErrStb),
    .strb      (strb)
  );

  prm_stat_dp #(
    .ES_W  (ES_W),
    .SES_W (SES_W),
    .ERR_W (ERR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .esCount  (esCount),
    .sesCount (sesCount),
    .errCount (errCount)
  );

endmodule

// File: rtl/prm_stat_chk.sv
module prm_stat_chk #(
  parameter int ES_W  = 16,
  parameter int SES_W = 16,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clr,
  input logic [7:0]       histByte,
  input logic             histValid,
  input logic             shiftStb,
  input logic             msgErrStb,
  input logic [ES_W-1:0]  esCount,
  input logic [SES_W-1:0] sesCount,
  input logic [ERR_W-1:0] errCount
);

  logic validShift;
  logic esHit;
  logic sesHit;
  assign validShift = shiftStb && histValid;
  assign esHit  = histByte[3] || histByte[4] || (histByte[2:0] > 3'd1);
  assign sesHit = histByte[4] || (histByte[2:0] == 3'b111);

  AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !validShift) |=> ($stable(esCount) && $stable(sesCount))); // R2

  AST_ES_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && validShift && esHit && (esCount != {ES_W{1'b1}}))
      |=> (esCount == ES_W'($past(esCount) + 1'b1))); // R3

  AST_SES_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && validShift && sesHit && (sesCount != {SES_W{1'b1}}))
      |=> (sesCount == SES_W'($past(sesCount) + 1'b1))); // R4

  AST_CLEAN_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !esHit) |=> $stable(esCount)); // R5

  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && msgErrStb && (errCount != {ERR_W{1'b1}}))
      |=> (errCount == ERR_W'($past(errCount) + 1'b1))); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && (esCount == {ES_W{1'b1}})) |=> (esCount == {ES_W{1'b1}})); // R7

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> ((esCount == '0) && (sesCount == '0) && (errCount == '0))); // R8

endmodule

bind prm_stat_top prm_stat_chk #(
  .ES_W  (ES_W),
  .SES_W (SES_W),
  .ERR_W (ERR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clr       (clr),
  .histByte  (histByte),
  .histValid (histValid),
  .shiftStb  (shiftStb),
  .msgErrStb (msgErrStb),
  .esCount   (esCount),
  .sesCount  (sesCount),
  .errCount  (errCount)
);

// File: tb/prm_stat_top_tb.sv
module prm_stat_top_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        clr;
  logic [7:0]  histByte;
  logic        histValid;
  logic        shiftStb;
  logic        msgErrStb;
  logic [15:0] esCount;
  logic [15:0] sesCount;
  logic [7:0]  errCount;

  int checks   = 0;
  int failures = 0;
  int expEs    = 0;
  int expSes   = 0;
  int expErr   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  prm_stat_top u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .clr       (clr),
    .histByte  (histByte),
    .histValid (histValid),
    .shiftStb  (shiftStb),
    .msgErrStb (msgErrStb),
    .esCount   (esCount),
    .sesCount  (sesCount),
    .errCount  (errCount)
  );

  function automatic bit erroredByte(input logic [7:0] b);
    return b[3] || b[4] || (int'(b[2:0]) >= 2);
  endfunction

  function automatic bit severeByte(input logic [7:0] b);
    return b[4] || (b[2:0] == 3'd7);
  endfunction

  task automatic checkAll(input string req);
    checks++;
    if (int'(esCount) != expEs || int'(sesCount) != expSes || int'(errCount) != expErr) begin
      failures++;
      $display("FAIL %s: actual es=%0d ses=%0d err=%0d expected es=%0d ses=%0d err=%0d",
               req, esCount, sesCount, errCount, expEs, expSes, expErr);
    end
  endtask

  // One cycle of stimulus; returns at the following falling edge.
  task automatic drive(input logic [7:0] b, input bit v, input bit sh,
                       input bit er, input bit cl);
    histByte = b; histValid = v; shiftStb = sh; msgErrStb = er; clr = cl;
    @(posedge clk);
    @(negedge clk);
    histByte = '0; histValid = 0; shiftStb = 0; msgErrStb = 0; clr = 0;
    if (cl) begin
      expEs = 0; expSes = 0; expErr = 0;
    end else begin
      if (sh && v && erroredByte(b) && expEs < 65535) expEs++;
      if (sh && v && severeByte(b) && expSes < 65535) expSes++;
      if (er && expErr < 255) expErr++;
    end
  endtask

  task automatic tReset();
    rstN = 0; clr = 0; histByte = '0; histValid = 0; shiftStb = 0; msgErrStb = 0;
    repeat (3) @(negedge clk);
    expEs = 0; expSes = 0; expErr = 0;
    checkAll("R1 during reset");
    rstN = 1;
    repeat (2) @(negedge clk);
    checkAll("R1 after release");
  endtask

  task automatic tAllBytes();
    drive(8'h00, 0, 0, 0, 1);
    for (int b = 0; b < 256; b++) begin
      drive(8'(b), 1, 1, 0, 0);
      checkAll("R3/R4 byte class");
    end
  endtask

  task automatic tCleanIgnored();
    drive(8'h00, 0, 0, 0, 1);
    drive(8'hE0, 1, 1, 0, 0);
    checkAll("R5 clean with bits 7..5 set");
    drive(8'hA1, 1, 1, 0, 0);
    checkAll("R5 code 1 with loopback/violation");
    drive(8'h60, 1, 1, 0, 0);
    checkAll("R5 slip and violation only");
  endtask

  task automatic tInvalid();
    drive(8'h17, 0, 1, 0, 0);
    checkAll("R2 invalid entry skipped");
    drive(8'h1F, 1, 0, 0, 0);
    checkAll("R2 no shift no change");
    drive(8'h08, 1, 1, 0, 0);
    checkAll("R9 single-cycle update");
  endtask

  task automatic tCoincident();
    drive(8'h10, 1, 1, 1, 0);
    checkAll("R6 err with severe shift");
    drive(8'h07, 0, 1, 1, 0);
    checkAll("R6 err with invalid shift");
    drive(8'h02, 1, 1, 1, 0);
    checkAll("R6 err with errored shift");
    drive(8'h00, 0, 0, 1, 0);
    checkAll("R6 err alone");
  endtask

  task automatic tClear();
    drive(8'h1F, 1, 1, 1, 1);
    checkAll("R8 clear beats strobes");
  endtask

  task automatic tSaturate();
    drive(8'h00, 0, 0, 0, 1);
    for (int i = 0; i < 65540; i++) drive(8'h10, 1, 1, 0, 0);
    checkAll("R7 seconds counters hold at max");
    for (int i = 0; i < 260; i++) drive(8'h00, 0, 0, 1, 0);
    checkAll("R7 error counter holds at max");
    drive(8'h00, 0, 0, 0, 1);
    checkAll("R8 clear from saturation");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tReset();
    tAllBytes();
    tCleanIgnored();
    tInvalid();
    tCoincident();
    tClear();
    tSaturate();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule